// File: doc/BRIEF.md
# Pin Transition Timestamp Channel

This block is a single capture channel. It watches one asynchronous input pin, brings it into the clock domain, and rejects pulses that are too short. It then timestamps the chosen transitions with the current value of one of two free-running 16-bit timer counts. Each timestamp goes into a two-entry queue. The queue reports its occupancy, and it also records that a third timestamp arrived while both entries were full.

Software, or a neighbouring sequencer, reads the queue with a one-cycle read strobe. The read always returns the oldest timestamp on `fifo_top`. A one-cycle clear strobe empties the queue at any time. A sticky event flag marks that at least one timestamp was stored. When the channel is built with the ADC trigger option, every stored timestamp also produces a one-cycle conversion-start pulse.

Top module: `cap_channel`

## Requirements
- R1: The pin passes through a two-stage synchroniser. A new level is accepted only after it has been seen in two consecutive synchronised samples. A pin high for a single clock produces no capture. When the pin changes before clock edge k, the resulting timestamp is written at edge k+5.
- R2: `edge_sel` chooses the captured transitions: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 both. With `cap_en` low, no transition is stored.
- R3: A capture stores `tmr1_cnt` when `tmr_sel` is 1 and `tmr2_cnt` when `tmr_sel` is 0. In both cases it stores the value present at the writing clock edge.
- R4: `fifo_stat` encodes 2'b00 empty, 2'b01 one entry, 2'b10 two entries and 2'b11 overflow. The first capture goes to `fifo_top` and the second to `fifo_bot`.
- R5: A capture into a full queue drops the oldest entry and keeps the two newest, with the older one on `fifo_top`. The status becomes 2'b11 and stays there, through further captures, until a read or a clear.
- R6: A read returns the oldest entry and moves `fifo_bot` to `fifo_top`. Status changes 01→00, 10→01 and 11→01. A read of an empty queue has no effect. A read and a capture at the same edge are handled read first.
- R7: A `cap_clr` pulse empties the queue and sets the status to 2'b00 at the next edge. It overrides a capture or read at that edge. It is not held, so the next capture is stored normally.
- R8: `cap_flag` sets on every stored capture and stays set until a `flag_clr` pulse. A capture at the same edge as `flag_clr` leaves the flag set.
- R9: With the ADC trigger option, `adc_start` is high for exactly the one cycle after each stored capture.
- R10: After reset, the status is 2'b00 and `cap_flag` and `adc_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 1 | Asynchronous capture pin |
| tmr1_cnt | input | 16 | Count of timer 1 |
| tmr2_cnt | input | 16 | Count of timer 2 |
| cap_en | input | 1 | Capture enable |
| edge_sel | input | 2 | Transition select code |
| tmr_sel | input | 1 | 1 = timer 1, 0 = timer 2 |
| cap_clr | input | 1 | Queue clear strobe |
| rd_stb | input | 1 | Queue read strobe |
| flag_clr | input | 1 | Write-one clear of the event flag |
| fifo_top | output | 16 | Oldest stored timestamp |
| fifo_bot | output | 16 | Newer stored timestamp |
| fifo_stat | output | 2 | Queue status code |
| cap_flag | output | 1 | Sticky capture event flag |
| adc_start | output | 1 | Conversion start pulse |

## Verification
The assertions check the control rules that can be judged one cycle at a time: the effect of the clear strobe, the status holding at overflow, the reads that leave overflow or drain a single entry, the stickiness of the flag, and the absence of stores with capture disabled. The other behaviours are checked by the bench's reference model, which runs on every clock in the scenarios. These are the timestamp values, the choice of timer, the pulse-width filtering and its latency, the transition selection, and the ordering of entries across overflow and simultaneous read and capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      ST_EMPTY = 2'b00,
      ST_ONE   = 2'b01,
      ST_TWO   = 2'b10,
      ST_LOST  = 2'b11
   } fifo_st_e;
endpackage

// File: rtl/cap_filter.sv
module cap_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_WIDTH   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cap_filter: SYNC_STAGES must be at least 2");
   end
   if (MIN_WIDTH < 1) begin : g_bad_width
      $error("cap_filter: MIN_WIDTH must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [MIN_WIDTH-1:0]   hist_q;
   logic                   synced;

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   if (MIN_WIDTH == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= synced;
      end
   end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '0;
         else        hist_q <= {hist_q[MIN_WIDTH-2:0], synced};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         level_o <= 1'b0;
      else if (&hist_q)   level_o <= 1'b1;
      else if (~|hist_q)  level_o <= 1'b0;
   end
endmodule

// File: rtl/cap_edge.sv
module cap_edge
   import cap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level_i,
   input  logic [1:0] edge_sel,
   output logic       hit_o
);
   logic prev_q;
   logic rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise = level_i & ~prev_q;
   assign fall = ~level_i & prev_q;

   always_comb begin
      unique case (edge_sel_e'(edge_sel))
         EDGE_RISE: hit_o = rise;
         EDGE_FALL: hit_o = fall;
         EDGE_ANY:  hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo
   import cap_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd,
   output logic [DW-1:0] top_o,
   output logic [DW-1:0] bot_o,
   output logic [1:0]    stat_o
);
   if (DW < 1) begin : g_bad_dw
      $error("cap_fifo: DW must be positive");
   end

   fifo_st_e      st_q, st_mid, st_nx;
   logic [DW-1:0] top_q, bot_q, top_mid, top_nx, bot_nx;
   logic          pop;

   assign pop = rd && (st_q != ST_EMPTY);

   // read stage
   always_comb begin
      st_mid  = st_q;
      top_mid = top_q;
      if (pop) begin
         if (st_q == ST_ONE) begin
            st_mid = ST_EMPTY;
         end else begin
            st_mid  = ST_ONE;
            top_mid = bot_q;
         end
      end
   end

   // write stage
   always_comb begin
      st_nx  = st_mid;
      top_nx = top_mid;
      bot_nx = bot_q;
      if (wr) begin
         unique case (st_mid)
            ST_EMPTY: begin st_nx = ST_ONE; top_nx = wr_data; end
            ST_ONE:   begin st_nx = ST_TWO; bot_nx = wr_data; end
            default:  begin
               st_nx  = ST_LOST;
               top_nx = bot_q;
               bot_nx = wr_data;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_EMPTY;
         top_q <= '0;
         bot_q <= '0;
      end else if (clr) begin
         st_q  <= ST_EMPTY;
      end else begin
         st_q  <= st_nx;
         top_q <= top_nx;
         bot_q <= bot_nx;
      end
   end

   assign top_o  = top_q;
   assign bot_o  = bot_q;
   assign stat_o = st_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
   import cap_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int MIN_WIDTH    = 2,
   parameter bit ADC_START_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_pin,
   input  logic [CNT_W-1:0] tmr1_cnt,
   input  logic [CNT_W-1:0] tmr2_cnt,
   input  logic             cap_en,
   input  logic [1:0]       edge_sel,
   input  logic             tmr_sel,
   input  logic             cap_clr,
   input  logic             rd_stb,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] fifo_top,
   output logic [CNT_W-1:0] fifo_bot,
   output logic [1:0]       fifo_stat,
   output logic             cap_flag,
   output logic             adc_start
);
   logic             level;
   logic             hit;
   logic             cap_wr;
   logic [CNT_W-1:0] stamp;

   cap_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_WIDTH(MIN_WIDTH)) u_filter (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .level_o(level)
   );

   cap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(level), .edge_sel(edge_sel), .hit_o(hit)
   );

   assign cap_wr = hit & cap_en;
   assign stamp  = tmr_sel ? tmr1_cnt : tmr2_cnt;

   cap_fifo #(.DW(CNT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(cap_clr), .wr(cap_wr), .wr_data(stamp),
      .rd(rd_stb), .top_o(fifo_top), .bot_o(fifo_bot), .stat_o(fifo_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cap_flag <= 1'b0;
      else if (cap_wr)   cap_flag <= 1'b1;
      else if (flag_clr) cap_flag <= 1'b0;
   end

   if (ADC_START_EN) begin : g_adc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) adc_start <= 1'b0;
         else        adc_start <= cap_wr;
      end
   end else begin : g_no_adc
      assign adc_start = 1'b0;
   end
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cap_en,
   input logic [1:0] edge_sel,
   input logic       cap_clr,
   input logic       rd_stb,
   input logic       flag_clr,
   input logic       cap_wr,
   input logic [1:0] fifo_stat,
   input logic       cap_flag,
   input logic       adc_start
);
   // R7
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_clr |=> fifo_stat == 2'b00);

   // R5
   lost_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_stat == 2'b11 && !rd_stb && !cap_clr) |=> fifo_stat == 2'b11);

   // R6
   lost_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_stat == 2'b11 && rd_stb && !cap_clr) |=> (fifo_stat == 2'b01 || fifo_stat == 2'b10));

   // R6
   drain_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_stat == 2'b01 && rd_stb && !cap_clr && !cap_wr) |=> fifo_stat == 2'b00);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !flag_clr) |=> cap_flag);

   // R9
   adc_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> cap_flag);

   // R2
   no_store_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en || edge_sel == 2'b00) |-> !cap_wr);
endmodule

bind cap_channel cap_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .edge_sel(edge_sel),
   .cap_clr(cap_clr), .rd_stb(rd_stb), .flag_clr(flag_clr), .cap_wr(cap_wr),
   .fifo_stat(fifo_stat), .cap_flag(cap_flag), .adc_start(adc_start)
);

// File: tb/cap_channel_tb.sv
module cap_channel_tb;
   localparam int SYNC = 2;
   localparam int MINW = 2;
   localparam int HLEN = SYNC + MINW + 1;
   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_pin = 1'b0;
   logic [15:0] tmr1_cnt = 16'h0000;
   logic [15:0] tmr2_cnt = 16'h8000;
   logic        cap_en = 1'b0;
   logic [1:0]  edge_sel = 2'b00;
   logic        tmr_sel = 1'b1;
   logic        cap_clr = 1'b0;
   logic        rd_stb = 1'b0;
   logic        flag_clr = 1'b0;
   logic [15:0] fifo_top, fifo_bot;
   logic [1:0]  fifo_stat;
   logic        cap_flag, adc_start;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 1'b0;

   cap_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr1_cnt(tmr1_cnt),
      .tmr2_cnt(tmr2_cnt), .cap_en(cap_en), .edge_sel(edge_sel), .tmr_sel(tmr_sel),
      .cap_clr(cap_clr), .rd_stb(rd_stb), .flag_clr(flag_clr), .fifo_top(fifo_top),
      .fifo_bot(fifo_bot), .fifo_stat(fifo_stat), .cap_flag(cap_flag), .adc_start(adc_start)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      tmr1_cnt <= tmr1_cnt + 16'd1;
      tmr2_cnt <= tmr2_cnt + 16'd3;
   end

   // reference model
   int        pins[$];
   int        m_q[$];
   bit        m_lost, m_lvl, m_prev, m_flag, m_adc;
   int        m_stat;

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         pins.delete();
         for (int i = 0; i < HLEN; i++) pins.push_back(0);
         m_q.delete();
         m_lost = 0; m_lvl = 0; m_prev = 0; m_flag = 0; m_adc = 0;
      end else begin
         bit rise, fall, hit, wr;
         int ts;
         bit all1, all0;
         rise = m_lvl && !m_prev;
         fall = !m_lvl && m_prev;
         case (edge_sel)
            2'b01:   hit = rise;
            2'b10:   hit = fall;
            2'b11:   hit = rise || fall;
            default: hit = 0;
         endcase
         wr = hit && cap_en;
         ts = tmr_sel ? int'(tmr1_cnt) : int'(tmr2_cnt);
         if (cap_clr) begin
            m_q.delete();
            m_lost = 0;
         end else begin
            if (rd_stb && m_q.size() > 0) begin
               void'(m_q.pop_front());
               m_lost = 0;
            end
            if (wr) begin
               if (m_q.size() == 2) begin
                  void'(m_q.pop_front());
                  m_lost = 1;
               end
               m_q.push_back(ts);
            end
         end
         if (wr) m_flag = 1;
         else if (flag_clr) m_flag = 0;
         m_adc = wr;
         pins.push_front(int'(cap_pin));
         void'(pins.pop_back());
         m_prev = m_lvl;
         all1 = 1; all0 = 1;
         for (int i = 0; i < MINW; i++) begin
            if (pins[1 + SYNC + i] == 0) all1 = 0;
            else all0 = 0;
         end
         if (all1) m_lvl = 1;
         else if (all0) m_lvl = 0;
      end
      m_stat = m_lost ? 3 : m_q.size();
      #2;
      if (rst_n && !done) begin
         check("R4", "fifo_stat", int'(fifo_stat), m_stat);
         if (m_q.size() >= 1) check("R3", "fifo_top", int'(fifo_top), m_q[0]);
         if (m_q.size() == 2) check("R5", "fifo_bot", int'(fifo_bot), m_q[1]);
         check("R8", "cap_flag", int'(cap_flag), int'(m_flag));
         check("R9", "adc_start", int'(adc_start), int'(m_adc));
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cycles > LIMIT && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
         finish_run();
      end
   end

   task automatic pulse(input int w);
      cap_pin = 1'b1;
      repeat (w) @(negedge clk);
      cap_pin = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic strobe_clr();
      cap_clr = 1'b1;
      @(negedge clk);
      cap_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic read_one();
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "fifo_stat", int'(fifo_stat), 0);
      check("R10", "cap_flag", int'(cap_flag), 0);
      check("R10", "adc_start", int'(adc_start), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      cap_en = 1'b1; edge_sel = 2'b01; tmr_sel = 1'b1;
      // R1: single-clock glitch is rejected, two clocks accepted
      pulse(1);
      check("R1", "stat after glitch", int'(fifo_stat), 0);
      pulse(2);
      check("R1", "stat after 2-clock pulse", int'(fifo_stat), 1);
      strobe_clr();

      // R1 latency: pin set before edge k, stored at edge k+5
      cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      check("R1", "stat before k+5", int'(fifo_stat), 0);
      @(negedge clk);
      check("R1", "stat after k+5", int'(fifo_stat), 1);
      cap_pin = 1'b0;
      repeat (8) @(negedge clk);
      strobe_clr();

      // R2 select codes and enable
      edge_sel = 2'b00; pulse(4);
      check("R2", "code 00 stores nothing", int'(fifo_stat), 0);
      edge_sel = 2'b01; cap_en = 1'b0; pulse(4);
      check("R2", "disabled stores nothing", int'(fifo_stat), 0);
      cap_en = 1'b1; edge_sel = 2'b10; pulse(4);
      check("R2", "falling only", int'(fifo_stat), 1);
      strobe_clr();
      edge_sel = 2'b11; pulse(4);
      check("R2", "both edges", int'(fifo_stat), 2);
      strobe_clr();

      // R3 timer 2 selection (values checked by model each cycle)
      edge_sel = 2'b01; tmr_sel = 1'b0; pulse(3);
      check("R3", "stat with timer 2", int'(fifo_stat), 1);
      tmr_sel = 1'b1; pulse(3);
      check("R4", "two entries", int'(fifo_stat), 2);

      // R5 overflow and persistence
      pulse(3);
      check("R5", "overflow code", int'(fifo_stat), 3);
      pulse(3);
      check("R5", "overflow held", int'(fifo_stat), 3);

      // R6 reads
      read_one();
      check("R6", "read from overflow", int'(fifo_stat), 1);
      read_one();
      check("R6", "read last", int'(fifo_stat), 0);
      read_one();
      check("R6", "read of empty", int'(fifo_stat), 0);

      // R6 read together with capture from two entries
      pulse(3); pulse(3);
      cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      check("R6", "read+capture from two", int'(fifo_stat), 2);
      cap_pin = 1'b0;
      repeat (8) @(negedge clk);

      // R7 clear together with capture, then normal capture
      pulse(3);
      check("R7", "pre-clear overflow", int'(fifo_stat), 3);
      cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      cap_clr = 1'b1;
      @(negedge clk);
      cap_clr = 1'b0;
      check("R7", "clear wins over capture", int'(fifo_stat), 0);
      cap_pin = 1'b0;
      repeat (8) @(negedge clk);
      pulse(3);
      check("R7", "capture after clear", int'(fifo_stat), 1);

      // R8 flag clear and set-wins
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", "flag cleared", int'(cap_flag), 0);
      cap_pin = 1'b1;
      repeat (5) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check("R8", "set wins over clear", int'(cap_flag), 1);
      // R9 pulse in the cycle after the store
      check("R9", "adc pulse", int'(adc_start), 1);
      @(negedge clk);
      check("R9", "adc pulse ends", int'(adc_start), 0);
      cap_pin = 1'b0;
      repeat (10) @(negedge clk);

      finish_run();
   end
endmodule